// File: doc/BRIEF.md
# NAND Flash Device Command Front End

This block is the device-side front end of a synthesizable NAND flash behavioural model. It watches the flash bus pins (chip select, write strobe, command-latch and address-latch qualifiers and the 8-bit I/O byte) through the system clock. Each rising edge of the write strobe taken while the chip is selected becomes one bus cycle, classified as a command, address or data byte.

Command bytes drive a sequencer that knows the single-byte opcodes and the setup/confirm pairs. Address bytes are gathered into a column and a 16-bit row: three bytes for page operations, two row bytes for block erase. A start-area pointer, chosen by the read opcode, offsets the received column. Write data during a program sequence leaves as a byte stream tagged with its page-register column, for a small page store beside the block. Every launched operation appears as a one-cycle pulse with its kind and address. Array operations hold a busy flag for a configurable number of cycles, and while busy only reset and status read get through.

Top module: `nand_cmd_front`

## Requirements
- R1: A bus cycle is taken only on a low-to-high transition of `wr_strobe_n` while `chip_sel_n` is low; with `cmd_latch` high it is a command (this wins over `addr_latch`), with only `addr_latch` high an address, otherwise data.
- R2: Command 90h gives an `op_vld` pulse with `op_kind`=2 (identify). Command FFh gives an `op_vld` pulse with `op_kind`=3 (reset), returns the sequencer to idle and ends busy. Command 70h raises `status_sel` without any pulse.
- R3: Commands 00h, 01h and 50h select start area 0, 256 or spare. After three address bytes (column, row low, row high), an `op_vld` pulse with `op_kind`=1 (read) carries `op_row`={high,low} and `op_col` = column byte, 256 + column byte, or 512 + low 4 bits of the column byte respectively.
- R4: 80h, three address bytes, data bytes, then 10h: each data byte appears on `wr_byte` with a `wr_vld` pulse, and `wr_col` counts up from the start column. 10h then gives `op_kind`=4 (program) with the start column and row.
- R5: 60h, two address bytes (row low, row high), then D0h gives `op_kind`=5 (erase) with that row and `op_col`=0.
- R6: After a read started with the 00h area, 8Ah followed by three address bytes gives `op_kind`=6 (copy-back) with the new column and row.
- R7: Read, program, erase and copy-back hold `busy` high for exactly BUSY_CYCLES cycles, starting the cycle after their `op_vld` pulse. `status_byte` is 40h when ready and 00h when busy.
- R8: While busy, every command other than FFh and 70h is ignored: it gives no pulse and leaves no sequence state behind.
- R9: An undefined opcode, 10h without a program setup, D0h without an erase setup, or 8Ah without a preceding 00h-area read gives a one-cycle `seq_err` pulse and returns the sequencer to idle.
- R10: Program data bytes beyond column 527 are dropped: no `wr_vld`.
- R11: After reset, `op_vld`, `seq_err`, `wr_vld`, `busy` and `status_sel` are low and `status_byte` is 40h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_n | input | 1 | Chip select, active low |
| wr_strobe_n | input | 1 | Write strobe, byte taken on its rising edge |
| cmd_latch | input | 1 | Marks the byte as a command |
| addr_latch | input | 1 | Marks the byte as an address |
| bus_in | input | 8 | I/O byte |
| op_vld | output | 1 | One-cycle pulse: an operation is launched |
| op_kind | output | 3 | 1 read, 2 identify, 3 reset, 4 program, 5 erase, 6 copy-back |
| op_col | output | COL_W | Start column of the operation |
| op_row | output | 16 | Row (page) address |
| seq_err | output | 1 | One-cycle pulse on a sequencing error |
| wr_vld | output | 1 | Program data byte valid |
| wr_byte | output | 8 | Program data byte |
| wr_col | output | COL_W | Page-register column of the data byte |
| busy | output | 1 | Array operation in progress |
| status_sel | output | 1 | Status read mode selected |
| status_byte | output | 8 | Status value, bit 6 set when ready |

## Verification
The embedded assertions watch on every cycle that bytes are only taken with the chip selected, that address capture never runs past its count, that data columns stay inside the page and only flow in the data phase, that an error always leaves the sequencer idle, that busy rises only after a launch, and that a blocked command while busy produces no pulse. The computed values are only visible in the bench's scenarios: the column offset of each start area, the row byte order, and the exact busy length. So are the pairing rules across whole sequences, such as a program setup swallowed during busy that turns a later 10h into an error. The bench sweeps every opcode byte in the idle state and several columns in each start area.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

    localparam int ROW_W = 16;

    typedef enum logic [1:0] {BUS_CMD, BUS_ADDR, BUS_DATA} bus_kind_e;

    typedef struct packed {
        logic      vld;
        bus_kind_e kind;
        logic [7:0] val;
    } bus_ev_t;

    typedef enum logic [2:0] {
        OPK_NONE  = 3'd0,
        OPK_READ  = 3'd1,
        OPK_IDENT = 3'd2,
        OPK_RESET = 3'd3,
        OPK_PROG  = 3'd4,
        OPK_ERASE = 3'd5,
        OPK_COPY  = 3'd6
    } op_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_RD_ADR, SQ_PG_ADR, SQ_PG_DAT, SQ_ER_ADR, SQ_ER_CNF, SQ_CB_ADR
    } seq_e;

    typedef enum logic [1:0] {AREA_LOW, AREA_HIGH, AREA_SPARE} area_e;

    localparam logic [7:0] OPC_RD_LOW  = 8'h00;
    localparam logic [7:0] OPC_RD_HIGH = 8'h01;
    localparam logic [7:0] OPC_RD_SPR  = 8'h50;
    localparam logic [7:0] OPC_IDENT   = 8'h90;
    localparam logic [7:0] OPC_RESET   = 8'hFF;
    localparam logic [7:0] OPC_STATUS  = 8'h70;
    localparam logic [7:0] OPC_PG_SET  = 8'h80;
    localparam logic [7:0] OPC_PG_GO   = 8'h10;
    localparam logic [7:0] OPC_ER_SET  = 8'h60;
    localparam logic [7:0] OPC_ER_GO   = 8'hD0;
    localparam logic [7:0] OPC_CB_GO   = 8'h8A;

    function automatic logic busy_pass(input logic [7:0] c);
        return (c == OPC_RESET) || (c == OPC_STATUS);
    endfunction

    function automatic logic addr_phase(input seq_e s);
        return (s == SQ_RD_ADR) || (s == SQ_PG_ADR) || (s == SQ_ER_ADR) || (s == SQ_CB_ADR);
    endfunction

    function automatic logic long_op(input op_kind_e k);
        return (k == OPK_READ) || (k == OPK_PROG) || (k == OPK_ERASE) || (k == OPK_COPY);
    endfunction

endpackage

// File: rtl/nand_bus_sampler.sv
module nand_bus_sampler
    import nand_fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       chip_sel_n,
    input  logic       wr_strobe_n,
    input  logic       cmd_latch,
    input  logic       addr_latch,
    input  logic [7:0] bus_in,
    output bus_ev_t    ev
);
    logic    strobe_q;
    logic    rise;
    bus_ev_t ev_q;

    assign rise = wr_strobe_n && !strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b1;
            ev_q     <= '0;
        end else begin
            strobe_q <= wr_strobe_n;
            ev_q.vld <= rise && !chip_sel_n;
            ev_q.val <= bus_in;
            if (cmd_latch)
                ev_q.kind <= BUS_CMD;
            else if (addr_latch)
                ev_q.kind <= BUS_ADDR;
            else
                ev_q.kind <= BUS_DATA;
        end
    end

    assign ev = ev_q;

    AST_EV_SELECTED: assert property (@(posedge clk) disable iff (rst)
        ev_q.vld |-> ($past(!chip_sel_n) && $past(wr_strobe_n))); // R1

endmodule

// File: rtl/nand_addr_asm.sv
module nand_addr_asm
    import nand_fe_pkg::*;
#(
    parameter int MAIN_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int COL_W       = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             take,
    input  logic             row_only,
    input  area_e            area,
    input  logic [7:0]       abyte,
    output logic             full,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row
);
    localparam int HALF_BASE = MAIN_BYTES / 2;
    localparam int SPARE_AW  = $clog2(SPARE_BYTES);

    logic [1:0]       cnt_q;
    logic [1:0]       need;
    logic [7:0]       raw_q;
    logic [ROW_W-1:0] row_q;

    assign need = row_only ? 2'd2 : 2'd3;
    assign full = (cnt_q == need);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            raw_q <= '0;
            row_q <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + 2'd1;
            if (row_only) begin
                if (cnt_q == 2'd0) row_q[7:0]  <= abyte;
                else               row_q[15:8] <= abyte;
            end else begin
                case (cnt_q)
                    2'd0:    raw_q       <= abyte;
                    2'd1:    row_q[7:0]  <= abyte;
                    default: row_q[15:8] <= abyte;
                endcase
            end
        end
    end

    always_comb begin
        case (area)
            AREA_HIGH:  col = COL_W'(HALF_BASE) + COL_W'(raw_q);
            AREA_SPARE: col = COL_W'(MAIN_BYTES) + COL_W'(raw_q[SPARE_AW-1:0]);
            default:    col = COL_W'(raw_q);
        endcase
    end

    assign row = row_q;

    AST_ADDR_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        take |-> (cnt_q < need)); // R3

endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic abort,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || abort)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CNT_W'(CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(load)); // R7

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        abort |=> !busy); // R2

endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
    import nand_fe_pkg::*;
#(
    parameter int PAGE_BYTES = 528,
    parameter int COL_W      = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev,
    input  logic             busy,
    input  logic             addr_full,
    input  logic [COL_W-1:0] addr_col,
    input  logic [ROW_W-1:0] addr_row,
    output logic             addr_clr,
    output logic             addr_take,
    output logic             row_only,
    output area_e            area,
    output logic             op_vld,
    output op_kind_e         op_kind,
    output logic [COL_W-1:0] op_col,
    output logic [ROW_W-1:0] op_row,
    output logic             seq_err,
    output logic             wd_vld,
    output logic [7:0]       wd_byte,
    output logic [COL_W-1:0] wd_col,
    output logic             stat_sel
);
    seq_e             seq_q;
    area_e            area_q;
    logic             arm_q;
    logic [COL_W-1:0] wcol_q;
    logic             cmd_ok;
    logic             data_ok;

    assign cmd_ok  = ev.vld && (ev.kind == BUS_CMD) && (!busy || busy_pass(ev.val));
    assign data_ok = ev.vld && (ev.kind == BUS_DATA) && !busy && (seq_q == SQ_PG_DAT)
                     && (wcol_q < COL_W'(PAGE_BYTES));

    always_comb begin
        addr_clr = 1'b0;
        if (cmd_ok) begin
            case (ev.val)
                OPC_RD_LOW, OPC_RD_HIGH, OPC_RD_SPR,
                OPC_PG_SET, OPC_ER_SET, OPC_RESET: addr_clr = 1'b1;
                OPC_CB_GO: addr_clr = arm_q && (seq_q == SQ_IDLE);
                default:   addr_clr = 1'b0;
            endcase
        end
    end

    assign addr_take = ev.vld && (ev.kind == BUS_ADDR) && !busy && addr_phase(seq_q) && !addr_full;
    assign row_only  = (seq_q == SQ_ER_ADR);
    assign area      = area_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q    <= SQ_IDLE;
            area_q   <= AREA_LOW;
            arm_q    <= 1'b0;
            wcol_q   <= '0;
            op_vld   <= 1'b0;
            op_kind  <= OPK_NONE;
            op_col   <= '0;
            op_row   <= '0;
            seq_err  <= 1'b0;
            wd_vld   <= 1'b0;
            wd_byte  <= '0;
            wd_col   <= '0;
            stat_sel <= 1'b0;
        end else begin
            op_vld  <= 1'b0;
            seq_err <= 1'b0;
            wd_vld  <= 1'b0;

            // address phase completes
            if (addr_full) begin
                case (seq_q)
                    SQ_RD_ADR: begin
                        op_vld  <= 1'b1;
                        op_kind <= OPK_READ;
                        op_col  <= addr_col;
                        op_row  <= addr_row;
                        arm_q   <= (area_q == AREA_LOW);
                        seq_q   <= SQ_IDLE;
                    end
                    SQ_PG_ADR: begin
                        wcol_q <= addr_col;
                        seq_q  <= SQ_PG_DAT;
                    end
                    SQ_ER_ADR: seq_q <= SQ_ER_CNF;
                    SQ_CB_ADR: begin
                        op_vld  <= 1'b1;
                        op_kind <= OPK_COPY;
                        op_col  <= addr_col;
                        op_row  <= addr_row;
                        seq_q   <= SQ_IDLE;
                    end
                    default: ;
                endcase
            end

            if (cmd_ok) begin
                arm_q    <= 1'b0;
                stat_sel <= 1'b0;
                case (ev.val)
                    OPC_STATUS: begin
                        stat_sel <= 1'b1;
                        arm_q    <= arm_q;
                    end
                    OPC_RESET: begin
                        op_vld  <= 1'b1;
                        op_kind <= OPK_RESET;
                        op_col  <= '0;
                        op_row  <= '0;
                        seq_q   <= SQ_IDLE;
                    end
                    OPC_IDENT: begin
                        op_vld  <= 1'b1;
                        op_kind <= OPK_IDENT;
                        op_col  <= '0;
                        op_row  <= '0;
                        seq_q   <= SQ_IDLE;
                    end
                    OPC_RD_LOW: begin
                        area_q <= AREA_LOW;
                        seq_q  <= SQ_RD_ADR;
                    end
                    OPC_RD_HIGH: begin
                        area_q <= AREA_HIGH;
                        seq_q  <= SQ_RD_ADR;
                    end
                    OPC_RD_SPR: begin
                        area_q <= AREA_SPARE;
                        seq_q  <= SQ_RD_ADR;
                    end
                    OPC_PG_SET: seq_q <= SQ_PG_ADR;
                    OPC_ER_SET: seq_q <= SQ_ER_ADR;
                    OPC_PG_GO: begin
                        seq_q <= SQ_IDLE;
                        if (seq_q == SQ_PG_DAT) begin
                            op_vld  <= 1'b1;
                            op_kind <= OPK_PROG;
                            op_col  <= addr_col;
                            op_row  <= addr_row;
                        end else begin
                            seq_err <= 1'b1;
                        end
                    end
                    OPC_ER_GO: begin
                        seq_q <= SQ_IDLE;
                        if (seq_q == SQ_ER_CNF) begin
                            op_vld  <= 1'b1;
                            op_kind <= OPK_ERASE;
                            op_col  <= '0;
                            op_row  <= addr_row;
                        end else begin
                            seq_err <= 1'b1;
                        end
                    end
                    OPC_CB_GO: begin
                        if (arm_q && seq_q == SQ_IDLE) begin
                            seq_q <= SQ_CB_ADR;
                        end else begin
                            seq_q   <= SQ_IDLE;
                            seq_err <= 1'b1;
                        end
                    end
                    default: begin
                        seq_q   <= SQ_IDLE;
                        seq_err <= 1'b1;
                    end
                endcase
            end

            if (data_ok) begin
                wd_vld  <= 1'b1;
                wd_byte <= ev.val;
                wd_col  <= wcol_q;
                wcol_q  <= wcol_q + 1'b1;
            end
        end
    end

    AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        seq_err |-> (seq_q == SQ_IDLE)); // R9

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({op_vld, seq_err})); // R9

    AST_DATA_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
        wd_vld |-> (wd_col < COL_W'(PAGE_BYTES))); // R10

    AST_DATA_PHASE_ONLY: assert property (@(posedge clk) disable iff (rst)
        wd_vld |-> (seq_q == SQ_PG_DAT)); // R4

endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
    import nand_fe_pkg::*;
#(
    parameter int MAIN_BYTES  = 512,
    parameter int SPARE_BYTES = 16,
    parameter int BUSY_CYCLES = 200,
    localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES,
    localparam int COL_W      = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chip_sel_n,
    input  logic             wr_strobe_n,
    input  logic             cmd_latch,
    input  logic             addr_latch,
    input  logic [7:0]       bus_in,
    output logic             op_vld,
    output logic [2:0]       op_kind,
    output logic [COL_W-1:0] op_col,
    output logic [15:0]      op_row,
    output logic             seq_err,
    output logic             wr_vld,
    output logic [7:0]       wr_byte,
    output logic [COL_W-1:0] wr_col,
    output logic             busy,
    output logic             status_sel,
    output logic [7:0]       status_byte
);
    bus_ev_t          ev;
    logic             a_clr, a_take, a_row_only, a_full;
    area_e            a_area;
    logic [COL_W-1:0] a_col;
    logic [ROW_W-1:0] a_row;
    op_kind_e         kind_w;
    logic             t_load, t_abort;

    nand_bus_sampler u_sampler (
        .clk         (clk),
        .rst         (rst),
        .chip_sel_n  (chip_sel_n),
        .wr_strobe_n (wr_strobe_n),
        .cmd_latch   (cmd_latch),
        .addr_latch  (addr_latch),
        .bus_in      (bus_in),
        .ev          (ev)
    );

    nand_addr_asm #(
        .MAIN_BYTES  (MAIN_BYTES),
        .SPARE_BYTES (SPARE_BYTES),
        .COL_W       (COL_W)
    ) u_addr (
        .clk      (clk),
        .rst      (rst),
        .clr      (a_clr),
        .take     (a_take),
        .row_only (a_row_only),
        .area     (a_area),
        .abyte    (ev.val),
        .full     (a_full),
        .col      (a_col),
        .row      (a_row)
    );

    nand_seq_ctrl #(
        .PAGE_BYTES (PAGE_BYTES),
        .COL_W      (COL_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .busy      (busy),
        .addr_full (a_full),
        .addr_col  (a_col),
        .addr_row  (a_row),
        .addr_clr  (a_clr),
        .addr_take (a_take),
        .row_only  (a_row_only),
        .area      (a_area),
        .op_vld    (op_vld),
        .op_kind   (kind_w),
        .op_col    (op_col),
        .op_row    (op_row),
        .seq_err   (seq_err),
        .wd_vld    (wr_vld),
        .wd_byte   (wr_byte),
        .wd_col    (wr_col),
        .stat_sel  (status_sel)
    );

    assign t_load  = op_vld && long_op(kind_w);
    assign t_abort = op_vld && (kind_w == OPK_RESET);

    nand_busy_timer #(
        .CYCLES (BUSY_CYCLES)
    ) u_busy (
        .clk   (clk),
        .rst   (rst),
        .load  (t_load),
        .abort (t_abort),
        .busy  (busy)
    );

    assign op_kind     = kind_w;
    assign status_byte = {1'b0, !busy, 6'b0};

    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (rst)
        (op_vld && long_op(kind_w)) |=> busy); // R7

    AST_BUSY_FILTER: assert property (@(posedge clk) disable iff (rst)
        (busy && ev.vld && ev.kind == BUS_CMD && !busy_pass(ev.val))
        |=> (!op_vld && !seq_err)); // R8

endmodule

// File: tb/test_nand_cmd_front.sv
module test_nand_cmd_front;

    localparam int BUSY = 40;
    localparam int COLW = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            chip_sel_n = 1'b1;
    logic            wr_n = 1'b1;
    logic            cmd_latch = 1'b0;
    logic            addr_latch = 1'b0;
    logic [7:0]      bus_in = '0;
    logic            op_vld;
    logic [2:0]      op_kind;
    logic [COLW-1:0] op_col;
    logic [15:0]     op_row;
    logic            seq_err;
    logic            wr_vld;
    logic [7:0]      wr_byte;
    logic [COLW-1:0] wr_col;
    logic            busy;
    logic            status_sel;
    logic [7:0]      status_byte;

    nand_cmd_front #(.BUSY_CYCLES(BUSY)) i_nand_cmd_front (
        .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .wr_strobe_n(wr_n),
        .cmd_latch(cmd_latch), .addr_latch(addr_latch), .bus_in(bus_in),
        .op_vld(op_vld), .op_kind(op_kind), .op_col(op_col), .op_row(op_row),
        .seq_err(seq_err), .wr_vld(wr_vld), .wr_byte(wr_byte), .wr_col(wr_col),
        .busy(busy), .status_sel(status_sel), .status_byte(status_byte)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int op_cnt = 0, err_cnt = 0, wr_cnt = 0, busy_run = 0;
    int last_kind = 0, last_col = 0, last_row = 0;
    int log_col [16];
    int log_byte[16];

    always @(negedge clk) begin
        if (!rst) begin
            if (op_vld) begin
                op_cnt++;
                last_kind = int'(op_kind);
                last_col  = int'(op_col);
                last_row  = int'(op_row);
            end
            if (seq_err) err_cnt++;
            if (wr_vld) begin
                if (wr_cnt < 16) begin
                    log_col[wr_cnt]  = int'(wr_col);
                    log_byte[wr_cnt] = int'(wr_byte);
                end
                wr_cnt++;
            end
            if (busy) busy_run++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic c, input logic a, input logic [7:0] v, input logic sel_n);
        @(negedge clk);
        chip_sel_n = sel_n; cmd_latch = c; addr_latch = a; bus_in = v; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        chip_sel_n = 1'b1; cmd_latch = 1'b0; addr_latch = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] v);  cyc(1'b1, 1'b0, v, 1'b0); endtask
    task automatic adr(input logic [7:0] v);  cyc(1'b0, 1'b1, v, 1'b0); endtask
    task automatic dat(input logic [7:0] v);  cyc(1'b0, 1'b0, v, 1'b0); endtask
    task automatic settle();                  repeat (3) @(negedge clk); endtask
    task automatic wait_ready();
        repeat (2) @(negedge clk);
        while (busy) @(negedge clk);
        settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int o0, e0, w0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle();

        // R11 reset state
        check(!op_vld && !seq_err && !wr_vld, "R11 pulses idle", int'(op_vld) + int'(seq_err) + int'(wr_vld), 0);
        check(!busy && !status_sel, "R11 busy/status_sel low", int'(busy) + int'(status_sel), 0);
        check(status_byte == 8'h40, "R11 status ready", int'(status_byte), 64);

        // R1 deselected and unqualified cycles are not commands
        o0 = op_cnt;
        cyc(1'b1, 1'b0, 8'hFF, 1'b1); settle();
        check(op_cnt == o0, "R1 deselected cycle ignored", op_cnt - o0, 0);
        cyc(1'b1, 1'b1, 8'h90, 1'b0); settle();
        check(op_cnt == o0 + 1 && last_kind == 2, "R1 cmd_latch wins", last_kind, 2);

        // R2 R9 sweep of all opcode bytes from idle
        for (int b = 0; b < 256; b++) begin
            bit exp_op, exp_err, known;
            int exp_kind;
            o0 = op_cnt; e0 = err_cnt;
            cmd(8'(b)); settle();
            known   = (b == 8'h00 || b == 8'h01 || b == 8'h50 || b == 8'h70 ||
                       b == 8'h80 || b == 8'h60 || b == 8'h90 || b == 8'hFF);
            exp_err = !known;
            exp_op  = (b == 8'h90 || b == 8'hFF);
            exp_kind = (b == 8'h90) ? 2 : 3;
            check((op_cnt - o0) == int'(exp_op) && (err_cnt - e0) == int'(exp_err) &&
                  (!exp_op || last_kind == exp_kind),
                  $sformatf("R2/R9 opcode %02h op/err", b),
                  (op_cnt - o0) * 10 + (err_cnt - e0), int'(exp_op) * 10 + int'(exp_err));
            if (b == 8'h70)
                check(status_sel == 1'b1, "R2 status read selected", int'(status_sel), 1);
            cmd(8'hFF); settle();
        end

        // R3 read column/row in each start area
        for (int ar = 0; ar < 3; ar++) begin
            for (int c = 0; c < 256; c += 37) begin
                int ec, er;
                logic [7:0] opc;
                opc = (ar == 0) ? 8'h00 : (ar == 1) ? 8'h01 : 8'h50;
                er  = ((c * 7 + ar) & 255) * 256 + ((c + 3 * ar) & 255);
                ec  = (ar == 0) ? c : (ar == 1) ? 256 + c : 512 + (c & 15);
                o0 = op_cnt;
                cmd(opc); adr(8'(c)); adr(8'(er)); adr(8'(er >> 8)); settle();
                check(op_cnt == o0 + 1 && last_kind == 1, "R3 read launched", last_kind, 1);
                check(last_col == ec, $sformatf("R3 area %0d column", ar), last_col, ec);
                check(last_row == er, "R3 row byte order", last_row, er);
                wait_ready();
            end
        end

        // R5 R7 R8 erase, busy window, blocked commands, status
        o0 = op_cnt; e0 = err_cnt; busy_run = 0;
        cmd(8'h60); adr(8'h34); adr(8'h12); cmd(8'hD0); settle();
        check(op_cnt == o0 + 1 && last_kind == 5, "R5 erase launched", last_kind, 5);
        check(last_row == 16'h1234 && last_col == 0, "R5 erase row", last_row, 16'h1234);
        check(busy == 1'b1, "R7 busy after erase", int'(busy), 1);
        o0 = op_cnt;
        cmd(8'h90); cmd(8'h80);
        check(op_cnt == o0 && err_cnt == e0, "R8 commands blocked while busy", op_cnt - o0, 0);
        cmd(8'h70); @(negedge clk);
        check(status_sel && status_byte == 8'h00, "R7 status busy", int'(status_byte), 0);
        wait_ready();
        check(status_byte == 8'h40, "R7 status ready", int'(status_byte), 64);
        check(busy_run == BUSY, "R7 busy length", busy_run, BUSY);
        // 80h swallowed during busy: later 10h has no setup
        w0 = wr_cnt; e0 = err_cnt;
        adr(8'h01); adr(8'h02); adr(8'h03); dat(8'h55); cmd(8'h10); settle();
        check(wr_cnt == w0 && err_cnt == e0 + 1, "R8 setup ignored while busy", err_cnt - e0, 1);

        // R4 program in main area
        o0 = op_cnt; w0 = wr_cnt;
        cmd(8'h00); cmd(8'h80); adr(8'd5); adr(8'h78); adr(8'h56);
        for (int i = 0; i < 6; i++) dat(8'(8'hA0 + i));
        cmd(8'h10); settle();
        check(wr_cnt == w0 + 6, "R4 data count", wr_cnt - w0, 6);
        for (int i = 0; i < 6; i++) begin
            if (w0 + i < 16) begin
                check(log_col[w0 + i] == 5 + i, "R4 data column", log_col[w0 + i], 5 + i);
                check(log_byte[w0 + i] == 8'hA0 + i, "R4 data byte", log_byte[w0 + i], 8'hA0 + i);
            end
        end
        check(op_cnt == o0 + 1 && last_kind == 4 && last_col == 5 && last_row == 16'h5678,
              "R4 program launched", last_kind * 1000 + last_col, 4005);
        // R2 reset during busy ends it
        o0 = op_cnt;
        cmd(8'hFF); settle();
        check(op_cnt == o0 + 1 && last_kind == 3 && !busy, "R2 reset ends busy", int'(busy), 0);

        // R10 spare program runs off page end
        w0 = 0;
        for (int i = 0; i < 16; i++) log_col[i] = 0;
        o0 = op_cnt; e0 = wr_cnt;
        cmd(8'h50); cmd(8'h80); adr(8'd12); adr(8'h00); adr(8'h01);
        for (int i = 0; i < 8; i++) dat(8'(i));
        cmd(8'h10); settle();
        check(wr_cnt == e0 + 4, "R10 bytes past 527 dropped", wr_cnt - e0, 4);
        check(last_kind == 4 && last_col == 524, "R4 spare program column", last_col, 524);
        wait_ready();

        // R9 mismatched confirms
        e0 = err_cnt; o0 = op_cnt;
        cmd(8'h80); adr(8'h00); adr(8'h00); adr(8'h00); cmd(8'hD0); settle();
        check(err_cnt == e0 + 1 && op_cnt == o0, "R9 D0h after program setup", err_cnt - e0, 1);
        cmd(8'h60); adr(8'h00); adr(8'h00); cmd(8'h10); settle();
        check(err_cnt == e0 + 2 && op_cnt == o0, "R9 10h after erase setup", err_cnt - e0, 2);

        // R6 copy-back
        cmd(8'h00); adr(8'd3); adr(8'h11); adr(8'h22); settle();
        wait_ready();
        o0 = op_cnt;
        cmd(8'h8A); adr(8'd7); adr(8'h33); adr(8'h44); settle();
        check(op_cnt == o0 + 1 && last_kind == 6, "R6 copy-back launched", last_kind, 6);
        check(last_col == 7 && last_row == 16'h4433, "R6 copy-back address", last_row, 16'h4433);
        wait_ready();
        e0 = err_cnt;
        cmd(8'h01); adr(8'd0); adr(8'd0); adr(8'd0); wait_ready();
        cmd(8'h8A); settle();
        check(err_cnt == e0 + 1, "R9 copy-back without 00h read", err_cnt - e0, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule